// File: doc/BRIEF.md
# Fixed-Interval Period Pulse Generator

This block derives periodic pulses from a nanosecond time base. The time base advances by a fixed number of nanoseconds (the tick period) each time a tick strobe arrives, and the block follows those strobes. It holds a set of independent channels, two by default. Each channel counts down a programmed interval in nanoseconds. When the interval is used up, the channel emits a pulse and raises a sticky event flag. All channels share one prescaler, and the prescaler sets how many ticks each pulse stays high. This gives a pulse one divided-output-clock period wide, not one clock cycle wide.

The interval value is programmed one tick period short of the wanted pulse period. To get a pulse period D that is a multiple of the tick period P, write D − P. The usual setting for channel 0 is one pulse per second, which software uses to discipline its clock. That value is 999,999,990 with a 10 ns tick and 999,999,995 with a 5 ns tick. Intervals are loaded through a shared data bus with one write strobe per channel. A write restarts that channel from its new value.

Top module: `interval_pulse_gen`

## Requirements
- R1: After reset every pulse output and every event flag is low. A channel that has never been written stays silent, whatever tick strobes arrive.
- R2: When `ivl_wr[i]` is high for a cycle, `ivl_data` is stored as channel i's interval. That channel does not fire in the write cycle, and a tick in the write cycle is ignored by that channel. The first tick after the write cycle restarts the countdown from the stored value, and that restart tick never fires.
- R3: Let I be the stored interval and P the tick period. Call the restart tick tick 0. The channel fires on tick N = floor(I/P)+1 and on every N-th tick after it, so I = D − P with D a multiple of P gives one fire every D nanoseconds. A channel fires only in a cycle with a tick strobe.
- R4: The pulse output rises in the cycle after a fire. It stays high through the following max(S,1)−1 ticks, where S is `prescale`, and it falls in the cycle after the max(S,1)-th tick that follows the fire. A prescaler of zero therefore acts as one. A fire that comes while the pulse is high restarts the full width.
- R5: A pulse output changes only in the cycle after a tick strobe or after a write to its own channel. Idle cycles between ticks leave it unchanged.
- R6: The event flag of a channel goes high in the cycle after that channel fires. It stays high until it is cleared.
- R7: A high `evt_clr[i]` clears event flag i in the next cycle. If channel i fires in the same cycle, the fire wins and the flag stays high.
- R8: A write to channel i forces pulse i low from the next cycle on. The write leaves event flag i unchanged.
- R9: Channels are independent. Writing, firing or clearing one channel never changes another channel's pulse or event flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick strobe, one cycle per tick |
| tick_ns | input | TW | Nanoseconds added to the time base per tick |
| prescale | input | SW | Shared output prescaler; pulse width in ticks (0 acts as 1) |
| ivl_data | input | IW | Interval value for the channel being written |
| ivl_wr | input | NCH | Per-channel write strobe for `ivl_data` |
| evt_clr | input | NCH | Write-one-to-clear for the event flags |
| pulse_out | output | NCH | Per-channel pulse outputs |
| evt_flag | output | NCH | Per-channel sticky event flags |

## Verification
The bound checker watches the local cycle-to-cycle rules on every cycle. It checks that a fire occurs only on a tick and never in a write cycle, that a fire raises the pulse and the flag in the next cycle, that pulses move only after a tick or a write, that flags hold or clear as R6 and R7 state, and that a write drops the pulse. The bench sweeps intervals, tick periods, prescalers, tick spacing and clear timing. Only that sweep shows the cadence and width arithmetic of R3 and R4, that the restart tick does not fire, and that a channel's behaviour is unaffected by the other channel.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_ARMED = 2'd1,
      CH_RUN   = 2'd2
   } ipg_state_e;

   // Pulse width in ticks for a given prescaler setting; zero acts as one.
   function automatic logic [31:0] ipg_width_of(input logic [31:0] presc);
      return (presc == 32'd0) ? 32'd1 : presc;
   endfunction

endpackage

// File: rtl/ipg_countdown.sv
module ipg_countdown
   import ipg_pkg::*;
#(
   parameter int IW = 32,
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [TW-1:0] period_i,
   input  logic          wr_i,
   input  logic [IW-1:0] data_i,
   output logic          fire_o
);

   ipg_state_e    st_q;
   logic [IW-1:0] ivl_q;
   logic [IW-1:0] cnt_q;
   logic [IW-1:0] per_ext;
   logic          short_left;

   assign per_ext    = IW'(period_i);
   assign short_left = (cnt_q < per_ext);
   assign fire_o     = tick_i && !wr_i && (st_q == CH_RUN) && short_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= CH_IDLE;
         ivl_q <= '0;
         cnt_q <= '0;
      end else if (wr_i) begin
         ivl_q <= data_i;
         st_q  <= CH_ARMED;
      end else if (tick_i) begin
         unique case (st_q)
            CH_ARMED: begin
               cnt_q <= ivl_q;
               st_q  <= CH_RUN;
            end
            CH_RUN: begin
               if (short_left) cnt_q <= ivl_q;
               else            cnt_q <= cnt_q - per_ext;
            end
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/ipg_stretch.sv
module ipg_stretch
   import ipg_pkg::*;
#(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          fire_i,
   input  logic          kill_i,
   input  logic          clr_i,
   input  logic [SW-1:0] presc_i,
   output logic          pulse_o,
   output logic          evt_o
);

   logic [SW-1:0] left_q;
   logic [SW-1:0] load_w;
   logic          evt_q;

   assign load_w  = SW'(ipg_width_of(32'(presc_i)));
   assign pulse_o = (left_q != '0);
   assign evt_o   = evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (kill_i) begin
         left_q <= '0;
      end else if (fire_i) begin
         left_q <= load_w;
      end else if (tick_i && (left_q != '0)) begin
         left_q <= left_q - SW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      evt_q <= 1'b0;
      else if (fire_i) evt_q <= 1'b1;
      else if (clr_i)  evt_q <= 1'b0;
   end

endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
   import ipg_pkg::*;
#(
   parameter int NCH = 2,
   parameter int IW  = 32,
   parameter int TW  = 8,
   parameter int SW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [TW-1:0]  tick_ns,
   input  logic [SW-1:0]  prescale,
   input  logic [IW-1:0]  ivl_data,
   input  logic [NCH-1:0] ivl_wr,
   input  logic [NCH-1:0] evt_clr,
   output logic [NCH-1:0] pulse_out,
   output logic [NCH-1:0] evt_flag
);

   logic [NCH-1:0] fire_vec;

   if (NCH < 1) begin : g_bad_nch
      $error("interval_pulse_gen: NCH must be at least 1");
   end
   if (TW > IW) begin : g_bad_tw
      $error("interval_pulse_gen: TW must not exceed IW");
   end
   if (SW < 1 || SW > 32) begin : g_bad_sw
      $error("interval_pulse_gen: SW must be 1..32");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ipg_countdown #(.IW(IW), .TW(TW)) u_cd (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick),
         .period_i (tick_ns),
         .wr_i     (ivl_wr[c]),
         .data_i   (ivl_data),
         .fire_o   (fire_vec[c])
      );

      ipg_stretch #(.SW(SW)) u_st (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_i  (tick),
         .fire_i  (fire_vec[c]),
         .kill_i  (ivl_wr[c]),
         .clr_i   (evt_clr[c]),
         .presc_i (prescale),
         .pulse_o (pulse_out[c]),
         .evt_o   (evt_flag[c])
      );
   end

endmodule

// File: rtl/ipg_checker.sv
module ipg_checker #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tick,
   input logic [NCH-1:0] ivl_wr,
   input logic [NCH-1:0] evt_clr,
   input logic [NCH-1:0] fire,
   input logic [NCH-1:0] pulse,
   input logic [NCH-1:0] evt
);

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      AST_FIRE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |-> tick); // R3
      AST_NO_FIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         ivl_wr[i] |-> !fire[i]); // R2
      AST_PULSE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |=> pulse[i]); // R4
      AST_PULSE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(pulse[i]) |-> ($past(tick) || $past(ivl_wr[i]))); // R5
      AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |=> evt[i]); // R6
      AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && !evt_clr[i]) |=> evt[i]); // R6
      AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_clr[i] && !fire[i]) |=> !evt[i]); // R7
      AST_WRITE_DROPS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         ivl_wr[i] |=> !pulse[i]); // R8
   end

endmodule

bind interval_pulse_gen ipg_checker #(.NCH(NCH)) u_ipg_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .ivl_wr  (ivl_wr),
   .evt_clr (evt_clr),
   .fire    (fire_vec),
   .pulse   (pulse_out),
   .evt     (evt_flag)
);

// File: tb/interval_pulse_gen_tb.sv
module interval_pulse_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int IW  = 32;
   localparam int TW  = 8;
   localparam int SW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick = 1'b0;
   logic [TW-1:0]  tick_ns = '0;
   logic [SW-1:0]  prescale = '0;
   logic [IW-1:0]  ivl_data = '0;
   logic [NCH-1:0] ivl_wr = '0;
   logic [NCH-1:0] evt_clr = '0;
   logic [NCH-1:0] pulse_out;
   logic [NCH-1:0] evt_flag;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   interval_pulse_gen #(.NCH(NCH), .IW(IW), .TW(TW), .SW(SW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .tick_ns   (tick_ns),
      .prescale  (prescale),
      .ivl_data  (ivl_data),
      .ivl_wr    (ivl_wr),
      .evt_clr   (evt_clr),
      .pulse_out (pulse_out),
      .evt_flag  (evt_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic tk);
      tick = tk;
      @(posedge clk);
      #1;
      tick = 1'b0;
   endtask

   function automatic int fired(input int f, input int n);
      return (f >= 1 && (f % n) == 0) ? 1 : 0;
   endfunction

   // Run one channel from a fresh write and compare every tick with the arithmetic model.
   task automatic run_case(input int ch, input int per, input int ivl, input int s,
                           input int clr_at, input bit wt, input int gap);
      int n  = ivl / per + 1;
      int w  = (s == 0) ? 1 : s;
      int oc = 1 - ch;
      int nt = 3 * n + 4;
      tick_ns  = TW'(per);
      prescale = SW'(s);
      // park the other channel on a long interval
      ivl_data   = 32'hFFFF_0000;
      ivl_wr     = '0;
      ivl_wr[oc] = 1'b1;
      step(1'b0);
      ivl_data   = IW'(ivl);
      ivl_wr     = '0;
      ivl_wr[ch] = 1'b1;
      evt_clr    = '1;
      step(wt);
      ivl_wr  = '0;
      evt_clr = '0;
      check("R8 pulse low after write", int'(pulse_out[ch]), 0);
      for (int t = 0; t < nt; t++) begin
         int pe = 0;
         int ee = 0;
         if (t == clr_at) evt_clr[ch] = 1'b1;
         step(1'b1);
         evt_clr = '0;
         for (int f = t - w + 1; f <= t; f++) if (fired(f, n) != 0) pe = 1;
         for (int f = 1; f <= t; f++)
            if (fired(f, n) != 0 && (clr_at < 0 || f >= clr_at)) ee = 1;
         check("R3/R4 pulse level", int'(pulse_out[ch]), pe);
         check((clr_at >= 0) ? "R7 event flag" : "R6 event flag", int'(evt_flag[ch]), ee);
         check("R9 other pulse", int'(pulse_out[oc]), 0);
         check("R9 other event", int'(evt_flag[oc]), 0);
         for (int g = 0; g < gap; g++) begin
            step(1'b0);
            check("R5 pulse holds between ticks", int'(pulse_out[ch]), pe);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset pulse", int'(pulse_out), 0);
      check("R1 reset event", int'(evt_flag), 0);
      rst_n = 1'b1;
      tick_ns = TW'(1);
      prescale = SW'(1);
      for (int k = 0; k < 6; k++) begin
         step(1'b1);
         check("R1 unwritten channel silent pulse", int'(pulse_out), 0);
         check("R1 unwritten channel silent event", int'(evt_flag), 0);
      end
      for (int p = 1; p <= 3; p += 2) begin
         for (int iv = 0; iv <= 4 * p; iv++) begin
            for (int s = 0; s <= 3; s++) begin
               int n  = iv / p + 1;
               int ca = (s == 2) ? 2 * n : ((s == 3) ? n + 1 : -1);
               run_case(iv % 2, p, iv, s, ca, (s % 2) == 1, (p == 3) ? 1 : 0);
            end
         end
      end
      // one-second-style setting scaled: D = 30 ns with a 3 ns tick -> write 27, fires every 10 ticks (R2, R3)
      run_case(0, 3, 27, 4, -1, 1'b1, 0);
      // wide pulse retriggered by a fire before it ends (R4)
      run_case(1, 2, 2, 5, -1, 1'b0, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule